// File: doc/BRIEF.md
# I2C Target Engine with Event Status Codes

This block answers as a target device on a two-wire I2C bus and hands every protocol event to a processor as an 8-bit status code. SCL and SDA are sampled through synchronizers. A START begins address collection. The engine accepts either its programmed 7-bit own address or, if enabled, the general-call address 0x00. It then acknowledges the address and runs byte-wide receive or transmit transfers.

After each event (address accepted, byte received, byte sent, end of transfer) the engine raises an interrupt flag and posts a status code. For most events it then holds SCL low, stalling the bus controller until software clears the flag. Software reads received bytes from the data register, loads bytes to send into the same register, and chooses ACK or NACK for incoming bytes with an acknowledge-enable bit.

Controller state machine: `ST_IDLE` moves to `ST_ADDR` on START. `ST_ADDR` moves to `ST_AACK` on an accepted address, or back to `ST_IDLE`. `ST_AACK` moves to `ST_HOLD`. `ST_HOLD` resumes to `ST_RX`, `ST_TX` or `ST_IDLE` once the flag is cleared. `ST_RX` moves to `ST_RACK` after eight bits, and `ST_RACK` moves to `ST_HOLD`. `ST_TX` moves to `ST_TACK` after eight bits, and `ST_TACK` moves to `ST_HOLD`. A STOP sends any active state to `ST_IDLE`, and a START sends it to `ST_ADDR`. Clearing the enable bit forces `ST_IDLE`.

Top module: `i2c_event_slave`

## Requirements
- R1: After reset the status register (offset 3) reads 0xF8, the own-address, data and control registers read 0x00, irq is 0, and neither bus line is pulled low.
- R2: With control bits ENAB (bit 6) and AAK (bit 2) set, a START followed by the own address (own-address register bits 7:1) and a write bit (0) is acknowledged by pulling SDA low in the ninth clock, sets IFLG (control bit 3) and posts 0x60.
- R3: When GCE (own-address register bit 0) is set, the address byte 0x00 is acknowledged and posts 0x70. Data bytes then post 0x90 when ACKed and 0x98 when NACKed. With GCE clear, address 0x00 gets no ACK.
- R4: In receive with AAK=1 each byte, taken MSB first, is ACKed, posts 0x80, and is readable from the data register (offset 1).
- R5: With AAK cleared during a receive, the next byte is NACKed (SDA left high) and posts 0x88. Clearing IFLG returns the engine to idle, so a later STOP posts nothing.
- R6: In receive, a STOP or repeated START that arrives before the first bit of a new byte completes sets IFLG and posts 0xA0 without holding SCL. After a repeated START the engine can be addressed again.
- R7: The own address with a read bit (1) is acknowledged and posts 0xA8. The data register byte is shifted out MSB first, and a master ACK posts 0xB8.
- R8: A transmitted byte that the master NACKs posts 0xC0, with SDA released. Clearing IFLG returns the engine to idle.
- R9: If AAK is 0 when IFLG is cleared to send a byte, that byte is the last: a master ACK of it posts 0xC8. While AAK stays 0 the engine ignores its own address.
- R10: After an address or byte event, SCL is held low while IFLG is 1 and is released within two cycles after software writes IFLG=0.
- R11: A non-matching address, or any address while ENAB=0 or AAK=0, gets no ACK, sets no flag and leaves status at 0xF8.
- R12: Status reads 0xF8 whenever IFLG is 0. Writing 1 to IFLG never sets it, and writing 1 leaves a pending flag set.
- R13: irq equals IEN (control bit 7) AND IFLG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 2 | Register offset: 0 own address, 1 data, 2 control, 3 status |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest events to reach are the ones tied to a precise bus moment. Examples are the 0xA0 code for a STOP or repeated START placed between bytes, and the 0xC8 code, which depends on the acknowledge-enable value at the instant the flag was cleared. The bench drives an open-drain bus model in which the master waits for SCL to rise, so the stall is honoured. Software steps are interleaved with master steps, including a control write that clears IFLG and AAK together, so each of these bus moments is produced on purpose.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_HOLD
    } eng_state_t;

    typedef enum logic [1:0] {
        NX_IDLE,
        NX_RX,
        NX_TX
    } resume_t;

    localparam int BYTE_W = 8;

    localparam logic [1:0] OFS_OWN  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int CB_IEN  = 7;
    localparam int CB_ENAB = 6;
    localparam int CB_IFLG = 3;
    localparam int CB_AAK  = 2;

    localparam logic [7:0] SC_IDLE    = 8'hF8;
    localparam logic [7:0] SC_RX_ADDR = 8'h60;
    localparam logic [7:0] SC_GC_ADDR = 8'h70;
    localparam logic [7:0] SC_RX_ACK  = 8'h80;
    localparam logic [7:0] SC_RX_NACK = 8'h88;
    localparam logic [7:0] SC_GC_ACK  = 8'h90;
    localparam logic [7:0] SC_GC_NACK = 8'h98;
    localparam logic [7:0] SC_END     = 8'hA0;
    localparam logic [7:0] SC_TX_ADDR = 8'hA8;
    localparam logic [7:0] SC_TX_ACK  = 8'hB8;
    localparam logic [7:0] SC_TX_NACK = 8'hC0;
    localparam logic [7:0] SC_TX_LAST = 8'hC8;

endpackage

// File: rtl/i2cs_line_watch.sv
module i2cs_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_q;
    logic         sda_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_in;
                    sda_pipe[g] <= sda_in;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g - 1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[TOP];
            sda_q <= sda_pipe[TOP];
        end
    end

    assign scl_lvl   = scl_pipe[TOP];
    assign sda_lvl   = sda_pipe[TOP];
    assign scl_rise  = !scl_q && scl_lvl;
    assign scl_fall  = scl_q && !scl_lvl;
    assign start_det = scl_q && scl_lvl && sda_q && !sda_lvl;
    assign stop_det  = scl_q && scl_lvl && !sda_q && sda_lvl;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter logic [6:0] RST_OWN = 7'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_sel,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       flag_set,
    input  logic [7:0] post_code,
    input  logic       rx_load,
    input  logic [7:0] rx_byte,
    output logic [6:0] own_addr,
    output logic       gce,
    output logic       ien,
    output logic       enab,
    output logic       aak,
    output logic       iflg,
    output logic [7:0] tx_byte
);
    logic [7:0] data_q;
    logic [7:0] code_q;
    logic [7:0] status;
    logic       wr_own;
    logic       wr_data;
    logic       wr_ctrl;

    assign wr_own  = cpu_wr && (cpu_sel == OFS_OWN);
    assign wr_data = cpu_wr && (cpu_sel == OFS_DATA);
    assign wr_ctrl = cpu_wr && (cpu_sel == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_addr <= RST_OWN;
            gce      <= 1'b0;
            data_q   <= '0;
            ien      <= 1'b0;
            enab     <= 1'b0;
            aak      <= 1'b0;
            iflg     <= 1'b0;
            code_q   <= SC_IDLE;
        end else begin
            if (wr_own) begin
                own_addr <= cpu_wdata[7:1];
                gce      <= cpu_wdata[0];
            end
            if (rx_load) begin
                data_q <= rx_byte;
            end else if (wr_data) begin
                data_q <= cpu_wdata;
            end
            if (wr_ctrl) begin
                ien  <= cpu_wdata[CB_IEN];
                enab <= cpu_wdata[CB_ENAB];
                aak  <= cpu_wdata[CB_AAK];
            end
            if (flag_set) begin
                iflg   <= 1'b1;
                code_q <= post_code;
            end else if (wr_ctrl && !cpu_wdata[CB_IFLG]) begin
                iflg <= 1'b0;
            end
        end
    end

    assign status  = iflg ? code_q : SC_IDLE;
    assign tx_byte = data_q;

    always_comb begin
        unique case (cpu_sel)
            OFS_OWN:  cpu_rdata = {own_addr, gce};
            OFS_DATA: cpu_rdata = data_q;
            OFS_CTRL: cpu_rdata = {ien, enab, 2'b00, iflg, aak, 2'b00};
            default:  cpu_rdata = status;
        endcase
    end

    // R12
    flag_only_by_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iflg) |-> $past(flag_set));

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enab,
    input  logic       aak,
    input  logic       gce,
    input  logic [6:0] own_addr,
    input  logic       iflg,
    input  logic [7:0] tx_byte,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       flag_set,
    output logic [7:0] post_code,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic       sda_drive_low,
    output logic       scl_drive_low
);
    localparam logic [3:0] FULL_CNT = 4'(BYTE_W);
    localparam logic [3:0] LAST_TX  = 4'(BYTE_W - 1);

    eng_state_t state, state_d;
    resume_t    resume;
    logic [7:0] shreg;
    logic [3:0] bit_cnt;
    logic       is_gc;
    logic       ack_sent;
    logic       last_tx;
    logic       mack;
    logic       rx_fresh;

    logic addr_full;
    logic own_hit;
    logic gc_hit;
    logic accept;
    logic bus_edge;

    assign addr_full = (bit_cnt == FULL_CNT);
    assign own_hit   = (shreg[7:1] == own_addr);
    assign gc_hit    = gce && (shreg == 8'h00);
    assign accept    = enab && aak && (own_hit || gc_hit);
    assign bus_edge  = start_det || stop_det;
    assign rx_byte   = shreg;

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start_det) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (stop_det)                    state_d = ST_IDLE;
                else if (start_det)              state_d = ST_ADDR;
                else if (scl_fall && addr_full)  state_d = accept ? ST_AACK : ST_IDLE;
            end
            ST_AACK, ST_RACK, ST_TACK: begin
                if (stop_det)       state_d = ST_IDLE;
                else if (start_det) state_d = ST_ADDR;
                else if (scl_fall)  state_d = ST_HOLD;
            end
            ST_RX: begin
                if (stop_det)                    state_d = ST_IDLE;
                else if (start_det)              state_d = ST_ADDR;
                else if (scl_fall && addr_full)  state_d = ST_RACK;
            end
            ST_TX: begin
                if (stop_det)                         state_d = ST_IDLE;
                else if (start_det)                   state_d = ST_ADDR;
                else if (scl_fall && bit_cnt == LAST_TX) state_d = ST_TACK;
            end
            ST_HOLD: begin
                if (!iflg && !flag_set) begin
                    unique case (resume)
                        NX_RX:   state_d = ST_RX;
                        NX_TX:   state_d = ST_TX;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!enab) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath and event posting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            is_gc     <= 1'b0;
            ack_sent  <= 1'b0;
            last_tx   <= 1'b0;
            mack      <= 1'b0;
            rx_fresh  <= 1'b0;
            resume    <= NX_IDLE;
            flag_set  <= 1'b0;
            post_code <= SC_IDLE;
            rx_load   <= 1'b0;
        end else begin
            flag_set <= 1'b0;
            rx_load  <= 1'b0;
            if (enab && state == ST_RX && rx_fresh && bus_edge) begin
                flag_set  <= 1'b1;
                post_code <= SC_END;
            end
            if (!enab) begin
                bit_cnt  <= '0;
                rx_fresh <= 1'b0;
            end else if (start_det) begin
                bit_cnt  <= '0;
                rx_fresh <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                    end
                    ST_ADDR: begin
                        if (scl_rise && !addr_full) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall && addr_full) begin
                            is_gc  <= gc_hit;
                            resume <= (!gc_hit && shreg[0]) ? NX_TX : NX_RX;
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            flag_set  <= 1'b1;
                            post_code <= is_gc ? SC_GC_ADDR :
                                         (resume == NX_TX) ? SC_TX_ADDR : SC_RX_ADDR;
                        end
                    end
                    ST_RX: begin
                        if (scl_rise && !addr_full) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall) rx_fresh <= 1'b0;
                        if (scl_fall && addr_full) begin
                            rx_load  <= 1'b1;
                            ack_sent <= aak;
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            flag_set <= 1'b1;
                            if (ack_sent) begin
                                post_code <= is_gc ? SC_GC_ACK : SC_RX_ACK;
                                resume    <= NX_RX;
                            end else begin
                                post_code <= is_gc ? SC_GC_NACK : SC_RX_NACK;
                                resume    <= NX_IDLE;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            shreg   <= {shreg[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) mack <= !sda_lvl;
                        if (scl_fall) begin
                            flag_set <= 1'b1;
                            if (!mack) begin
                                post_code <= SC_TX_NACK;
                                resume    <= NX_IDLE;
                            end else if (last_tx) begin
                                post_code <= SC_TX_LAST;
                                resume    <= NX_IDLE;
                            end else begin
                                post_code <= SC_TX_ACK;
                                resume    <= NX_TX;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (state_d != ST_HOLD) begin
                            bit_cnt  <= '0;
                            rx_fresh <= (resume == NX_RX);
                            if (resume == NX_TX) begin
                                shreg   <= tx_byte;
                                last_tx <= !aak;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line outputs
    always_comb begin
        sda_drive_low = 1'b0;
        scl_drive_low = 1'b0;
        unique case (state)
            ST_AACK: sda_drive_low = 1'b1;
            ST_RACK: sda_drive_low = ack_sent;
            ST_TX:   sda_drive_low = !shreg[7];
            ST_HOLD: scl_drive_low = 1'b1;
            default: ;
        endcase
    end

    // R10
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !iflg && !flag_set && enab) |=> !scl_drive_low);

    // R11
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enab |=> (!sda_drive_low && !scl_drive_low));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && post_code == SC_TX_NACK) |-> !sda_drive_low);

    // R2
    ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) && state != ST_TX) |-> $past(scl_fall));

endmodule

// File: rtl/i2c_event_slave.sv
module i2c_event_slave
    import i2cs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] RST_OWN     = 7'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_sel,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       irq
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic       flag_set, rx_load;
    logic [7:0] post_code, rx_byte, tx_byte;
    logic [6:0] own_addr;
    logic       gce, ien, enab, aak, iflg;

    i2cs_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_regs #(.RST_OWN(RST_OWN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .flag_set  (flag_set),
        .post_code (post_code),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .own_addr  (own_addr),
        .gce       (gce),
        .ien       (ien),
        .enab      (enab),
        .aak       (aak),
        .iflg      (iflg),
        .tx_byte   (tx_byte)
    );

    i2cs_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enab          (enab),
        .aak           (aak),
        .gce           (gce),
        .own_addr      (own_addr),
        .iflg          (iflg),
        .tx_byte       (tx_byte),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .flag_set      (flag_set),
        .post_code     (post_code),
        .rx_load       (rx_load),
        .rx_byte       (rx_byte),
        .sda_drive_low (sda_pull),
        .scl_drive_low (scl_pull)
    );

    // scl_lvl is observed through scl_rise/scl_fall only
    logic unused_lvl;
    assign unused_lvl = scl_lvl;

    assign irq = ien && iflg;

    // R13
    irq_tracks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ien && ($rose(iflg) || $rose(ien))));

endmodule

// File: tb/i2c_event_slave_tb.sv
module i2c_event_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cpu_sel;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       m_scl, m_sda;
    logic       scl_pull, sda_pull, irq;
    logic       scl_bus, sda_bus;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign scl_bus = m_scl & ~scl_pull;
    assign sda_bus = m_sda & ~sda_pull;

    i2c_event_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .scl_in    (scl_bus),
        .sda_in    (sda_bus),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .irq       (irq)
    );

    localparam logic [7:0] OWN_W = 8'h54;
    localparam logic [7:0] OWN_R = 8'h55;
    localparam logic [7:0] CTL_ON = 8'hC4;

    // {addr byte, data byte, ack expected, entry code, byte code}
    localparam logic [32:0] VEC [5] = '{
        {8'h54, 8'hA5, 1'b1, 8'h60, 8'h80},
        {8'h00, 8'h3C, 1'b1, 8'h70, 8'h90},
        {8'h26, 8'h11, 1'b0, 8'hF8, 8'hF8},
        {8'h01, 8'h00, 1'b0, 8'hF8, 8'hF8},
        {8'h54, 8'hC3, 1'b1, 8'h60, 8'h80}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (8) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel;
        #1 d = cpu_rdata;
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        do @(negedge clk); while (!scl_bus);
        qwait();
    endtask

    task automatic m_start();
        m_sda = 1'b1; qwait();
        scl_up();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; qwait();
        scl_up();
        m_sda = 1'b1; qwait();
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait();
            scl_up();
            m_scl = 1'b0; qwait();
        end
        m_sda = 1'b1; qwait();
        scl_up();
        ack = !sda_bus;
        m_scl = 1'b0; qwait();
    endtask

    task automatic m_read(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl_up();
            b = {b[6:0], sda_bus};
            m_scl = 1'b0;
        end
        qwait();
        m_sda = nack; qwait();
        scl_up();
        m_scl = 1'b0; qwait();
        m_sda = 1'b1;
    endtask

    task automatic status_is(input string tag, input logic [7:0] exp);
        logic [7:0] s;
        cpu_read(2'd3, s);
        check(tag, s, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       ack;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        cpu_sel = '0; cpu_wr = 1'b0; cpu_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        status_is("R1 status", 8'hF8);
        cpu_read(2'd2, rd); check("R1 ctrl", rd, 8'h00);
        cpu_read(2'd0, rd); check("R1 own", rd, 8'h00);
        cpu_read(2'd1, rd); check("R1 data", rd, 8'h00);
        check("R1 lines/irq", {5'd0, scl_pull, sda_pull, irq}, 8'h00);

        cpu_write(2'd0, OWN_R);            // own 0x2A, GCE=1
        // R12 writing IFLG=1 does not set it
        cpu_write(2'd2, 8'hCC);
        cpu_read(2'd2, rd); check("R12 ctrl readback", rd, CTL_ON);
        status_is("R12 status idle", 8'hF8);

        // table-driven receive transfers (R2 R3 R4 R6 R11)
        for (int v = 0; v < 5; v++) begin
            m_start();
            m_write(VEC[v][32:25], ack);
            check($sformatf("R2/R11 addr ack vec %0d", v), {7'd0, ack}, {7'd0, VEC[v][16]});
            status_is($sformatf("R2/R3 entry code vec %0d", v), VEC[v][15:8]);
            if (VEC[v][16]) begin
                cpu_write(2'd2, CTL_ON);
                m_write(VEC[v][24:17], ack);
                check($sformatf("R4 byte ack vec %0d", v), {7'd0, ack}, 8'd1);
                status_is($sformatf("R4/R3 byte code vec %0d", v), VEC[v][7:0]);
                cpu_read(2'd1, rd);
                check($sformatf("R4 data vec %0d", v), rd, VEC[v][24:17]);
                cpu_write(2'd2, CTL_ON);
                m_stop();
                status_is($sformatf("R6 stop code vec %0d", v), 8'hA0);
                cpu_write(2'd2, CTL_ON);
                status_is($sformatf("R12 cleared vec %0d", v), 8'hF8);
            end else begin
                m_stop();
            end
        end

        // R10 stretch, then R5 NACK on AAK=0
        m_start();
        m_write(OWN_W, ack);
        repeat (50) @(negedge clk);
        check("R10 scl held", {6'd0, scl_pull, scl_bus}, 8'h02);
        cpu_write(2'd2, 8'hC0);            // clear IFLG and AAK
        repeat (2) @(negedge clk);
        check("R10 scl released", {7'd0, scl_pull}, 8'h00);
        m_write(8'h5E, ack);
        check("R5 nack", {7'd0, ack}, 8'h00);
        status_is("R5 code", 8'h88);
        cpu_write(2'd2, 8'hC0);
        m_stop();
        status_is("R5 idle after stop", 8'hF8);
        cpu_write(2'd2, CTL_ON);

        // R3 general call NACK, then GCE off
        m_start();
        m_write(8'h00, ack);
        status_is("R3 gc entry", 8'h70);
        cpu_write(2'd2, 8'hC0);
        m_write(8'h42, ack);
        check("R3 gc nack", {7'd0, ack}, 8'h00);
        status_is("R3 gc nack code", 8'h98);
        cpu_write(2'd2, CTL_ON);
        m_stop();
        cpu_write(2'd0, OWN_W);            // GCE=0
        m_start();
        m_write(8'h00, ack);
        check("R3 gc off no ack", {7'd0, ack}, 8'h00);
        status_is("R3 gc off status", 8'hF8);
        m_stop();
        cpu_write(2'd0, OWN_R);

        // R7 transmit, R9 last byte
        m_start();
        m_write(OWN_R, ack);
        check("R7 read addr ack", {7'd0, ack}, 8'h01);
        status_is("R7 entry", 8'hA8);
        cpu_write(2'd1, 8'h96);
        cpu_write(2'd2, CTL_ON);
        m_read(1'b0, rd);
        check("R7 tx byte", rd, 8'h96);
        status_is("R7 ack code", 8'hB8);
        cpu_write(2'd1, 8'h3B);
        cpu_write(2'd2, 8'hC0);
        m_read(1'b0, rd);
        check("R9 last byte", rd, 8'h3B);
        status_is("R9 code", 8'hC8);
        cpu_write(2'd2, 8'hC0);
        m_stop();
        status_is("R9 idle", 8'hF8);
        m_start();
        m_write(OWN_R, ack);
        check("R9 ignored with AAK=0", {7'd0, ack}, 8'h00);
        m_stop();
        cpu_write(2'd2, CTL_ON);

        // R8 master NACK
        m_start();
        m_write(OWN_R, ack);
        cpu_write(2'd1, 8'hF0);
        cpu_write(2'd2, CTL_ON);
        m_read(1'b1, rd);
        check("R8 tx byte", rd, 8'hF0);
        status_is("R8 code", 8'hC0);
        check("R8 sda released", {7'd0, sda_pull}, 8'h00);
        cpu_write(2'd2, CTL_ON);
        m_stop();
        status_is("R8 idle", 8'hF8);

        // R6 repeated start after ack, then re-address
        m_start();
        m_write(OWN_W, ack);
        cpu_write(2'd2, CTL_ON);
        m_write(8'h77, ack);
        cpu_write(2'd2, CTL_ON);
        m_start();
        status_is("R6 rstart code", 8'hA0);
        cpu_write(2'd2, CTL_ON);
        m_write(OWN_W, ack);
        check("R6 readdress ack", {7'd0, ack}, 8'h01);
        status_is("R6 readdress code", 8'h60);
        cpu_write(2'd2, CTL_ON);
        m_stop();
        cpu_write(2'd2, CTL_ON);

        // R11 ENAB=0
        cpu_write(2'd2, 8'h84);
        m_start();
        m_write(OWN_W, ack);
        check("R11 disabled no ack", {7'd0, ack}, 8'h00);
        status_is("R11 disabled status", 8'hF8);
        m_stop();

        // R13 irq gating, R12 write-1 keeps flag
        cpu_write(2'd2, 8'h44);
        m_start();
        m_write(OWN_W, ack);
        status_is("R13 flag set", 8'h60);
        check("R13 irq masked", {7'd0, irq}, 8'h00);
        cpu_write(2'd2, 8'hCC);
        check("R13 irq on", {7'd0, irq}, 8'h01);
        status_is("R12 write 1 keeps flag", 8'h60);
        cpu_write(2'd2, CTL_ON);
        m_stop();
        cpu_write(2'd2, CTL_ON);
        status_is("R12 final idle", 8'hF8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule